// File: doc/BRIEF.md
# Write-Protected Paged Byte Store

This block models a byte-wide non-volatile store that is protected against accidental writes. A register array holds the contents. A host reaches the array through a single-cycle access strobe with a write flag, an address and data. Reads return array bytes one clock after the strobe.

To change the array, the host must first write a three-step key without any other access in between. After the key, the host loads any number of bytes, all inside one 128-byte page. The load ends when the bus stays silent for a programmable number of cycles. The block then enters a timed programming phase. During that phase, any read returns a polling word instead of array data: the top bit is the complement of the last loaded byte's top bit, and bit 6 flips on every read. When the phase ends, the loaded bytes are in the array and the block is locked again.

Software polls the store until two consecutive reads agree. A write that leaves the page during loading throws the whole load away and sets a fault flag that holds until reset.

Top module: `prot_page_eeprom`

## Requirements
- R1: After reset every byte reads 0xFF, the fault output is 0 and the store is locked. A read strobe sampled at a clock edge places the byte on `acc_rdata` at that same edge.
- R2: The store unlocks after three consecutive writes: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Only the low `ADDR_W` bits of these addresses are compared. The key writes do not change the array.
- R3: A write while locked leaves the array unchanged.
- R4: Between key steps, a read or a non-matching write aborts the key and returns the store to locked. Later key steps then do not unlock it.
- R5: After unlock, the first write latches its page (address divided by 128). Further writes inside that page are held back. Reads during loading return the unchanged array bytes.
- R6: During loading, a write to another page discards all loaded bytes, relocks the store and sets `page_fault`. The flag stays at 1 until reset.
- R7: Programming starts only after `IDLE_CYC` consecutive cycles with no access while loading. Any read or write restarts that count.
- R8: During programming a read at any address returns {~L[7], T, L[5:0]}, where L is the last loaded byte. T is 0 on the first such read and alternates on each later read. Programming lasts `PROG_CYC` cycles.
- R9: Writes during programming are ignored, both for the array and for the page being programmed.
- R10: After programming every loaded byte (the last write to each offset) is in the array. Normal reads resume, and the store is locked, so a write without a new key has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access strobe, one access per cycle in which it is high |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data or polling word, registered |
| page_fault | output | 1 | Sticky flag: a load was aborted by a write outside its page |

## Verification
The bench builds the store with a 10-bit address (eight pages), an 8-cycle idle timeout and a 24-cycle programming time. With these values, each full key, load, idle, poll and program round fits in about a hundred cycles. Many random page loads therefore run within the cycle budget. The short idle timeout lets the bench place an access exactly one cycle before the timeout would expire. The short programming time leaves room for several polls while still showing the return to normal reads. The unlock addresses fold into page 2 and page 5 of the small array, so the bench also checks that key writes never land in the array.

// File: rtl/ppe_pkg.sv
// Shared types and constants for the protected page store.
// Assumes addresses of at most 16 bits; key addresses are truncated to ADDR_W.
package ppe_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOAD   = 2'd2,
        ST_PROG   = 2'd3
    } ppe_state_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_D0     = 8'hAA;
    localparam logic [7:0]  KEY_D1     = 8'h55;
    localparam logic [7:0]  KEY_D2     = 8'hA0;

    // Polling word shown during programming: inverted top bit, toggle, low bits.
    function automatic logic [7:0] poll_word(input logic [7:0] last, input logic tog);
        return {~last[7], tog, last[5:0]};
    endfunction

endpackage

// File: rtl/ppe_unlock.sv
// Three-step key detector.
// Tracks the key while 'arm' is high (store locked). Any access that does not
// match the expected step returns the detector to step 0. Idle cycles between
// steps are allowed. 'grant' is high in the cycle of a matching final step.
module ppe_unlock
    import ppe_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              acc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              grant
);
    localparam logic [ADDR_W-1:0] KA = KEY_ADDR_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] KB = KEY_ADDR_B[ADDR_W-1:0];

    logic [1:0]        step_q;
    logic [ADDR_W-1:0] exp_addr;
    logic [7:0]        exp_data;
    logic              match;

    // Expected address and data for the current step.
    always_comb begin
        unique case (step_q)
            2'd0:    begin exp_addr = KA; exp_data = KEY_D0; end
            2'd1:    begin exp_addr = KB; exp_data = KEY_D1; end
            default: begin exp_addr = KA; exp_data = KEY_D2; end
        endcase
    end

    assign match = wr && (addr == exp_addr) && (wdata == exp_data);
    assign grant = arm && acc && match && (step_q == 2'd2);

    // Step register: advance on a match, fall back to step 0 on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 2'd0;
        end else if (!arm) begin
            step_q <= 2'd0;
        end else if (acc) begin
            if (match && step_q != 2'd2) step_q <= step_q + 2'd1;
            else                         step_q <= 2'd0;
        end
    end

    // R4
    key_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && acc && !wr) |=> (step_q == 2'd0));

endmodule

// File: rtl/ppe_pagebuf.sv
// Page load buffer: one byte lane and a valid bit per page offset, plus the
// latched page index and the last byte written. The first write after a clear
// latches the page. The caller must only write inside the latched page.
module ppe_pagebuf #(
    parameter int PAGE_BYTES = 128,
    parameter int OFF_W      = 7,
    parameter int PG_W       = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [PG_W-1:0]            wr_page,
    input  logic [OFF_W-1:0]           wr_off,
    input  logic [7:0]                 wr_data,
    output logic [PG_W-1:0]            page_q,
    output logic [PAGE_BYTES-1:0]      valid_q,
    output logic [PAGE_BYTES-1:0][7:0] data_q,
    output logic [7:0]                 last_q
);

    // Page latch and last-byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            last_q <= 8'h00;
        end else if (!clr && wr_en) begin
            if (valid_q == '0) page_q <= wr_page;
            last_q <= wr_data;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic [7:0] lane_d;
        logic       lane_v;

        // One byte lane: capture on a write to this offset, drop on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_d <= 8'h00;
                lane_v <= 1'b0;
            end else if (clr) begin
                lane_v <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(g)) begin
                lane_d <= wr_data;
                lane_v <= 1'b1;
            end
        end

        assign data_q[g]  = lane_d;
        assign valid_q[g] = lane_v;
    end

    // R5
    page_locality_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && valid_q != '0) |-> (wr_page == page_q));

endmodule

// File: rtl/ppe_timer.sv
// Shared cycle counter for the idle timeout and the programming time.
// Assumes run_idle and run_prog are never high together.
// idle_done fires after IDLE_CYC cycles in a row with run_idle high and kick low.
// prog_done fires in the PROG_CYC-th cycle of run_prog.
module ppe_timer #(
    parameter int IDLE_CYC = 20000,
    parameter int PROG_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_idle,
    input  logic kick,
    input  logic run_prog,
    output logic idle_done,
    output logic prog_done
);
    localparam int MAXC = (IDLE_CYC > PROG_CYC) ? IDLE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    assign idle_done = run_idle && !kick && (cnt_q == CW'(IDLE_CYC - 1));
    assign prog_done = run_prog && (cnt_q == CW'(PROG_CYC - 1));

    // Counter: restart on an access, on a finished interval or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!(run_idle || run_prog)) begin
            cnt_q <= '0;
        end else if ((run_idle && kick) || idle_done || prog_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    idle_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_idle && kick) |=> (cnt_q == '0));

endmodule

// File: rtl/prot_page_eeprom.sv
// Write-protected paged byte store.
// Holds a 2**ADDR_W byte array that only accepts changes after a three-step
// key. Bytes then load into one page, and the page is committed after an
// idle timeout and a timed programming phase. Reads are registered (one
// clock). Assumes PAGE_BYTES is a power of two smaller than the array.
module prot_page_eeprom
    import ppe_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 128,
    parameter int IDLE_CYC   = 20000,
    parameter int PROG_CYC   = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              page_fault
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int DEPTH = 1 << ADDR_W;

    ppe_state_e                 state_q;
    logic [7:0]                 mem_q [DEPTH];
    logic                       grant;
    logic                       in_page;
    logic                       buf_wr;
    logic                       fault;
    logic                       buf_clr;
    logic                       idle_done;
    logic                       prog_done;
    logic                       tog_q;
    logic                       rd;
    logic [PG_W-1:0]            buf_page;
    logic [PAGE_BYTES-1:0]      buf_valid;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [7:0]                 buf_last;

    assign rd      = acc_en && !acc_wr;
    assign in_page = (buf_page == acc_addr[ADDR_W-1:OFF_W]);
    assign buf_wr  = acc_en && acc_wr &&
                     ((state_q == ST_OPEN) || (state_q == ST_LOAD && in_page));
    assign fault   = (state_q == ST_LOAD) && acc_en && acc_wr && !in_page;
    assign buf_clr = fault || prog_done;

    ppe_unlock #(.ADDR_W(ADDR_W)) i_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (state_q == ST_LOCKED),
        .acc   (acc_en),
        .wr    (acc_wr),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .grant (grant)
    );

    ppe_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) i_pagebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_page (acc_addr[ADDR_W-1:OFF_W]),
        .wr_off  (acc_addr[OFF_W-1:0]),
        .wr_data (acc_wdata),
        .page_q  (buf_page),
        .valid_q (buf_valid),
        .data_q  (buf_data),
        .last_q  (buf_last)
    );

    ppe_timer #(.IDLE_CYC(IDLE_CYC), .PROG_CYC(PROG_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_idle  (state_q == ST_LOAD),
        .kick      (acc_en),
        .run_prog  (state_q == ST_PROG),
        .idle_done (idle_done),
        .prog_done (prog_done)
    );

    // Control state: locked -> open -> loading -> programming -> locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            unique case (state_q)
                ST_LOCKED: if (grant)     state_q <= ST_OPEN;
                ST_OPEN:   if (buf_wr)    state_q <= ST_LOAD;
                ST_LOAD: begin
                    if (fault)            state_q <= ST_LOCKED;
                    else if (idle_done)   state_q <= ST_PROG;
                end
                ST_PROG:   if (prog_done) state_q <= ST_LOCKED;
                default:                  state_q <= ST_LOCKED;
            endcase
        end
    end

    // Sticky fault flag for an out-of-page write during loading.
    always_ff @(posedge clk) begin
        if (!rst_n)     page_fault <= 1'b0;
        else if (fault) page_fault <= 1'b1;
    end

    // Polling toggle: cleared on entry to programming, flipped by each read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         tog_q <= 1'b0;
        else if (idle_done)                 tog_q <= 1'b0;
        else if (state_q == ST_PROG && rd)  tog_q <= ~tog_q;
    end

    // Array: erased at reset, loaded page committed when programming ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (prog_done) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_valid[i]) mem_q[{buf_page, OFF_W'(i)}] <= buf_data[i];
            end
        end
    end

    // Read port: polling word during programming, array byte otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= 8'hFF;
        end else if (rd) begin
            acc_rdata <= (state_q == ST_PROG) ? poll_word(buf_last, tog_q)
                                              : mem_q[acc_addr];
        end
    end

    // R2
    open_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) == ST_LOCKED)
            |-> $past(acc_en && acc_wr && acc_wdata == KEY_D2));

    // R7
    prog_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_LOAD) |-> !$past(acc_en));

    // R9
    prog_buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(buf_valid));

    // R6
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(page_fault) |-> page_fault);

    // R8
    poll_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && rd) |=> (acc_rdata[7] != buf_last[7]));

    // R8
    poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG && rd && $past(rd))
            |=> (acc_rdata[6] != $past(acc_rdata[6])));

endmodule

// File: tb/test_prot_page_eeprom.sv
`timescale 1ns/1ps
module test_prot_page_eeprom;
    localparam int AW    = 10;
    localparam int IDLE  = 8;
    localparam int PROG  = 24;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] KA = 10'h155;
    localparam logic [AW-1:0] KB = 10'h2AA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = 8'h00;
    logic [7:0]    acc_rdata;
    logic          page_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] mdl [DEPTH];

    always #2.5 clk = ~clk;

    prot_page_eeprom #(.ADDR_W(AW), .PAGE_BYTES(128), .IDLE_CYC(IDLE), .PROG_CYC(PROG))
    i_prot_page_eeprom (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .page_fault(page_fault)
    );

    function automatic logic [7:0] exp_poll(input logic [7:0] last, input logic t);
        return {~last[7], t, last[5:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task starts and ends at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        d = acc_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0);
    endtask

    initial begin
        logic [7:0] r;
        void'($urandom(32'd20240517));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 fault after reset", {7'd0, page_fault}, 8'h00);
        rd(10'h000, r); chk("R1 erased byte 0", r, 8'hFF);
        rd(10'h3FF, r); chk("R1 erased top byte", r, 8'hFF);

        // R3: write while locked
        wr(10'h010, 8'h12); rd(10'h010, r); chk("R3 locked write ignored", r, 8'hFF);

        // R4: read between steps, then mismatched data
        wr(KA, 8'hAA); rd(10'h000, r); wr(KB, 8'h55); wr(KA, 8'hA0);
        wr(10'h020, 8'h34); idle(IDLE + PROG + 4);
        rd(10'h020, r); chk("R4 read aborts key", r, 8'hFF);
        wr(KA, 8'hAA); wr(KB, 8'h54); wr(KB, 8'h55); wr(KA, 8'hA0);
        wr(10'h021, 8'h35); idle(IDLE + PROG + 4);
        rd(10'h021, r); chk("R4 bad data aborts key", r, 8'hFF);
        rd(KA, r); chk("R2 key write not stored", r, 8'hFF);

        // R2/R5/R7/R8/R9/R10: page load at both page ends
        unlock();
        wr(10'h080, 8'h5A); wr(10'h0FF, 8'hC3);
        idle(IDLE - 1); rd(10'h080, r); chk("R5 read during load is old data", r, 8'hFF);
        idle(IDLE - 1); rd(10'h0FF, r); chk("R7 access restarts idle count", r, 8'hFF);
        idle(IDLE);
        rd(10'h3A0, r); chk("R8 first poll", r, exp_poll(8'hC3, 1'b0));
        rd(10'h080, r); chk("R8 second poll toggles", r, exp_poll(8'hC3, 1'b1));
        wr(10'h081, 8'h77);
        rd(10'h0FF, r); chk("R8 third poll", r, exp_poll(8'hC3, 1'b0));
        idle(PROG);
        rd(10'h080, r); chk("R10 offset 0 committed", r, 8'h5A);
        rd(10'h0FF, r); chk("R10 offset 127 committed", r, 8'hC3);
        rd(10'h081, r); chk("R9 write during program ignored", r, 8'hFF);
        mdl[10'h080] = 8'h5A; mdl[10'h0FF] = 8'hC3;
        wr(10'h090, 8'h11); idle(IDLE + PROG + 4);
        rd(10'h090, r); chk("R10 relocked after program", r, 8'hFF);
        chk("R6 no fault yet", {7'd0, page_fault}, 8'h00);

        // R6: write outside the latched page
        unlock();
        wr(10'h100, 8'h66); wr(10'h180, 8'h77);
        chk("R6 fault set", {7'd0, page_fault}, 8'h01);
        idle(IDLE + PROG + 4);
        rd(10'h100, r); chk("R6 load discarded", r, 8'hFF);
        rd(10'h180, r); chk("R6 stray write discarded", r, 8'hFF);

        // Random page loads mixed with locked writes
        for (int it = 0; it < 30; it++) begin
            logic [2:0]    pg;
            int            n;
            logic [AW-1:0] a;
            logic [AW-1:0] wa [8];
            logic [7:0]    d;
            logic [7:0]    last;
            a = AW'($urandom % DEPTH);
            wr(a, 8'($urandom));
            rd(a, r); chk("R3 random locked write", r, mdl[a]);
            unlock();
            pg = 3'($urandom % 8);
            n = 1 + ($urandom % 8);
            last = 8'h00;
            for (int k = 0; k < n; k++) begin
                wa[k] = {pg, 7'($urandom % 128)};
                d = 8'($urandom);
                wr(wa[k], d);
                mdl[wa[k]] = d;
                last = d;
            end
            idle(IDLE);
            rd(AW'($urandom % DEPTH), r); chk("R8 random poll", r, exp_poll(last, 1'b0));
            rd(AW'($urandom % DEPTH), r); chk("R8 random poll toggle", r, exp_poll(last, 1'b1));
            idle(PROG);
            for (int k = 0; k < n; k++) begin
                rd(wa[k], r); chk("R10 random readback", r, mdl[wa[k]]);
            end
        end
        chk("R6 fault still sticky", {7'd0, page_fault}, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule